// File: doc/BRIEF.md
# Serial Port Power-Save Wake Controller

This block decides when a serial port, and the module behind it, may drop into a low-power idle state and when it has to come back. A 3-bit mode select picks the policy. Mode 0 turns power saving off. Modes 1 and 4 put the port to sleep after a run of frame ticks with no received byte. Mode 2 follows the RTS line and mode 3 follows the DTR line. The block drives the enable of an external UART receiver, a flag that reports whether the module is idle, a CTS output and a qualifier that marks which received byte strobes may be passed on.

A port that wakes does not become fully active at once. It first spends a wake delay of a fixed number of frame ticks with the UART enabled and the idle flag still set. Every byte that arrives during that delay is discarded, including the character whose edge caused the wake-up. Only after the delay does the qualifier pass bytes through. The control lines and the receive line are asynchronous, so each passes through two flip-flops before edges are detected. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `uart_psave_ctrl`

## Requirements
- R1: After reset, uart_en is 1, idle_flag is 0 and cts_out is 1.
- R2: With mode_sel at 0, or at any value from 5 to 7, the port never idles, whatever the frame ticks, and every rx_byte_stb is passed on as rx_valid.
- R3: In modes 1 and 4, IDLE_TICKS frame ticks with no valid byte end the active state: uart_en goes to 0 and idle_flag goes to 1.
- R4: A valid byte restarts the inactivity count. When a valid byte and the frame tick that would expire the count arrive in the same cycle, the byte wins and the port stays active.
- R5: In modes 1 and 4 with hwfc_en at 0, a 0-to-1 edge on rxd_in while idle sets uart_en to 1 within four clock cycles, with idle_flag still 1.
- R6: In modes 1 and 4 with hwfc_en at 1, an edge on rxd_in does not wake an idle port.
- R7: While idle_flag is 1, rx_valid stays 0, so the wake character is dropped. WAKE_TICKS frame ticks after a wake-up, idle_flag clears and bytes become valid.
- R8: In modes 1 and 4, a 0-to-1 edge on dtr_in wakes an idle port.
- R9: In mode 3, the port stays active while dtr_in is 1, whatever the frame ticks. It goes idle within four cycles of dtr_in going to 0, and while idle it ignores rxd_in edges.
- R10: In mode 2, the port stays active while rts_in is 1 and goes idle when rts_in is 0. An rxd_in edge does not wake it.
- R11: In mode 3 with hwfc_en at 1, cts_out equals uart_en. In every other case cts_out is 1.
- R12: A wake caused only by a wake character, with no further data, still ends in idle after the wake delay plus IDLE_TICKS frame ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Power-save policy, 0 to 4; 5 to 7 behave as 0 |
| hwfc_en | input | 1 | Hardware flow control enabled |
| dtr_in | input | 1 | DTR line, 1 = ON, asynchronous |
| rts_in | input | 1 | RTS line, 1 = ON, asynchronous |
| rxd_in | input | 1 | Receive data line, asynchronous |
| rx_byte_stb | input | 1 | One-cycle strobe per byte from the UART receiver |
| frame_tick | input | 1 | One-cycle frame time base pulse |
| uart_en | output | 1 | UART receiver enable |
| idle_flag | output | 1 | 1 while idle or during the wake delay |
| cts_out | output | 1 | Clear-to-send output |
| rx_valid | output | 1 | Qualified byte strobe |

## Verification
A received byte and the frame tick that would expire the inactivity count can land in the same clock cycle. The bench counts the port down to one tick short of the limit, then raises rx_byte_stb and frame_tick on the same edge. It passes when the port is still active afterwards and a full IDLE_TICKS further ticks are needed to reach idle. A shortened count, or a port that sleeps at once, shows the count was not restarted.

// File: rtl/psave_pkg.sv
package psave_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_WAKING = 2'd1,
    ST_IDLE   = 2'd2
  } psave_state_e;

  localparam logic [2:0] MODE_OFF     = 3'd0;
  localparam logic [2:0] MODE_TIMED_A = 3'd1;
  localparam logic [2:0] MODE_RTS     = 3'd2;
  localparam logic [2:0] MODE_DTR     = 3'd3;
  localparam logic [2:0] MODE_TIMED_B = 3'd4;

  localparam int unsigned LINE_DTR = 0;
  localparam int unsigned LINE_RTS = 1;
  localparam int unsigned LINE_RXD = 2;
  localparam int unsigned N_LINES  = 3;

endpackage

// File: rtl/psave_sync.sv
module psave_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_async,
  output logic [WIDTH-1:0] line_lvl,
  output logic [WIDTH-1:0] line_rise
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        meta_q <= line_async[i];
        sync_q <= meta_q;
        hist_q <= sync_q;
      end
    end

    assign line_lvl[i]  = sync_q;
    assign line_rise[i] = sync_q & ~hist_q;
  end

endmodule

// File: rtl/psave_tick_counter.sv
module psave_tick_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done    = tick & ~clear & at_last;
  assign cnt_en  = clear | tick;

  always_comb begin
    if (clear || done) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/psave_fsm.sv
module psave_fsm
  import psave_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         m_off,
  input  logic         m_timed,
  input  logic         m_rts,
  input  logic         m_dtr,
  input  logic         hwfc_en,
  input  logic         dtr_lvl,
  input  logic         dtr_rise,
  input  logic         rts_lvl,
  input  logic         rxd_rise,
  input  logic         wake_done,
  input  logic         inact_done,
  output psave_state_e state
);

  psave_state_e state_q;
  psave_state_e state_d;
  logic         hold_lost;
  logic         wake_req;

  assign hold_lost = (m_rts & ~rts_lvl) | (m_dtr & ~dtr_lvl);
  assign wake_req  = (m_timed & dtr_rise)
                   | (m_timed & ~hwfc_en & rxd_rise)
                   | (m_rts & rts_lvl)
                   | (m_dtr & dtr_lvl);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (m_off) begin
          state_d = ST_ACTIVE;
        end else if (hold_lost || (m_timed && inact_done)) begin
          state_d = ST_IDLE;
        end
      end
      ST_WAKING: begin
        if (m_off) begin
          state_d = ST_ACTIVE;
        end else if (hold_lost) begin
          state_d = ST_IDLE;
        end else if (wake_done) begin
          state_d = ST_ACTIVE;
        end
      end
      ST_IDLE: begin
        if (m_off) begin
          state_d = ST_ACTIVE;
        end else if (wake_req) begin
          state_d = ST_WAKING;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/uart_psave_ctrl.sv
module uart_psave_ctrl
  import psave_pkg::*;
#(
  parameter int unsigned IDLE_TICKS = 2000,
  parameter int unsigned WAKE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       hwfc_en,
  input  logic       dtr_in,
  input  logic       rts_in,
  input  logic       rxd_in,
  input  logic       rx_byte_stb,
  input  logic       frame_tick,
  output logic       uart_en,
  output logic       idle_flag,
  output logic       cts_out,
  output logic       rx_valid
);

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic m_off;
  logic m_timed;
  logic m_rts;
  logic m_dtr;

  assign m_timed = (mode_sel == MODE_TIMED_A) || (mode_sel == MODE_TIMED_B);
  assign m_rts   = (mode_sel == MODE_RTS);
  assign m_dtr   = (mode_sel == MODE_DTR);
  assign m_off   = ~(m_timed | m_rts | m_dtr);

  logic [N_LINES-1:0] lines_async;
  logic [N_LINES-1:0] lines_lvl;
  logic [N_LINES-1:0] lines_rise;

  assign lines_async[LINE_DTR] = dtr_in;
  assign lines_async[LINE_RTS] = rts_in;
  assign lines_async[LINE_RXD] = rxd_in;

  psave_sync #(
    .WIDTH(N_LINES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .line_async(lines_async),
    .line_lvl  (lines_lvl),
    .line_rise (lines_rise)
  );

  psave_state_e state;
  logic         is_active;
  logic         byte_ok;
  logic         wake_done;
  logic         inact_done;
  logic         wake_clear;
  logic         inact_clear;

  assign is_active   = (state == ST_ACTIVE);
  assign byte_ok     = rx_byte_stb & is_active;
  assign wake_clear  = (state != ST_WAKING);
  assign inact_clear = ~is_active | ~m_timed | byte_ok;

  psave_tick_counter #(
    .LIMIT(WAKE_TICKS)
  ) u_wake_cnt (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .clear(wake_clear),
    .tick (frame_tick),
    .done (wake_done)
  );

  psave_tick_counter #(
    .LIMIT(IDLE_TICKS)
  ) u_inact_cnt (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .clear(inact_clear),
    .tick (frame_tick),
    .done (inact_done)
  );

  psave_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .m_off     (m_off),
    .m_timed   (m_timed),
    .m_rts     (m_rts),
    .m_dtr     (m_dtr),
    .hwfc_en   (hwfc_en),
    .dtr_lvl   (lines_lvl[LINE_DTR]),
    .dtr_rise  (lines_rise[LINE_DTR]),
    .rts_lvl   (lines_lvl[LINE_RTS]),
    .rxd_rise  (lines_rise[LINE_RXD]),
    .wake_done (wake_done),
    .inact_done(inact_done),
    .state     (state)
  );

  assign uart_en   = (state != ST_IDLE);
  assign idle_flag = ~is_active;
  assign cts_out   = (m_dtr && hwfc_en) ? uart_en : 1'b1;
  assign rx_valid  = byte_ok;

endmodule

// File: rtl/psave_checker.sv
module psave_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input logic       hwfc_en,
  input logic       uart_en,
  input logic       idle_flag,
  input logic       cts_out,
  input logic       rx_valid
);

  assert_off_mode_awake_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd0) |=> (uart_en && !idle_flag)
  );

  assert_no_valid_while_idle_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    idle_flag |-> !rx_valid
  );

  assert_wake_passes_delay_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(uart_en) |-> idle_flag
  );

  assert_sleep_needs_saving_mode_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(uart_en) |-> ($past(mode_sel) != 3'd0)
  );

  assert_active_implies_enabled_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(idle_flag) |-> uart_en
  );

  assert_cts_follows_wake_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd3 && hwfc_en && $rose(uart_en)) |-> cts_out
  );

endmodule

bind uart_psave_ctrl psave_checker u_psave_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .hwfc_en  (hwfc_en),
  .uart_en  (uart_en),
  .idle_flag(idle_flag),
  .cts_out  (cts_out),
  .rx_valid (rx_valid)
);

// File: tb/uart_psave_ctrl_bench.sv
module uart_psave_ctrl_bench;

  localparam int unsigned IDLE_T = 6;
  localparam int unsigned WAKE_T = 3;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic       hwfc_en;
  logic       dtr_in;
  logic       rts_in;
  logic       rxd_in;
  logic       rx_byte_stb;
  logic       frame_tick;
  logic       uart_en;
  logic       idle_flag;
  logic       cts_out;
  logic       rx_valid;

  int checks;
  int fails;
  bit done;

  uart_psave_ctrl #(
    .IDLE_TICKS(IDLE_T),
    .WAKE_TICKS(WAKE_T)
  ) u_uart_psave_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .hwfc_en    (hwfc_en),
    .dtr_in     (dtr_in),
    .rts_in     (rts_in),
    .rxd_in     (rxd_in),
    .rx_byte_stb(rx_byte_stb),
    .frame_tick (frame_tick),
    .uart_en    (uart_en),
    .idle_flag  (idle_flag),
    .cts_out    (cts_out),
    .rx_valid   (rx_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
    end
  endtask

  task automatic send_byte(output bit valid);
    @(negedge clk);
    rx_byte_stb = 1'b1;
    #1 valid = rx_valid;
    @(negedge clk);
    rx_byte_stb = 1'b0;
  endtask

  task automatic rxd_pulse();
    @(negedge clk);
    rxd_in = 1'b1;
    cyc(5);
    rxd_in = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mode_sel = 3'd0; hwfc_en = 1'b0;
    dtr_in = 1'b0; rts_in = 1'b0; rxd_in = 1'b0;
    rx_byte_stb = 1'b0; frame_tick = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    check("R1 uart_en", uart_en, 1);
    check("R1 idle_flag", idle_flag, 0);
    check("R1 cts_out", cts_out, 1);
  endtask

  task automatic t_mode_off();
    bit v;
    mode_sel = 3'd0;
    ticks(20);
    check("R2 uart_en mode0", uart_en, 1);
    check("R2 idle mode0", idle_flag, 0);
    send_byte(v);
    check("R2 valid mode0", v, 1);
    mode_sel = 3'd6;
    ticks(20);
    check("R2 idle mode6", idle_flag, 0);
    send_byte(v);
    check("R2 valid mode6", v, 1);
  endtask

  task automatic t_timeout();
    bit v;
    mode_sel = 3'd1;
    cyc(2);
    ticks(IDLE_T - 1);
    check("R3 still active", uart_en, 1);
    ticks(1);
    check("R3 uart_en off", uart_en, 0);
    check("R3 idle", idle_flag, 1);
    send_byte(v);
    check("R7 byte dropped while idle", v, 0);
  endtask

  task automatic t_wake_data();
    bit v;
    rxd_pulse();
    check("R5 uart_en after data edge", uart_en, 1);
    check("R5 idle_flag during delay", idle_flag, 1);
    send_byte(v);
    check("R7 wake char dropped", v, 0);
    ticks(WAKE_T - 1);
    check("R7 still in delay", idle_flag, 1);
    ticks(1);
    check("R7 active after delay", idle_flag, 0);
    send_byte(v);
    check("R7 byte valid after delay", v, 1);
  endtask

  task automatic t_restart();
    bit v;
    ticks(IDLE_T - 1);
    send_byte(v);
    ticks(IDLE_T - 1);
    check("R4 restart keeps active", uart_en, 1);
    @(negedge clk);
    frame_tick = 1'b1;
    rx_byte_stb = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    rx_byte_stb = 1'b0;
    check("R4 same-cycle byte wins", idle_flag, 0);
    ticks(IDLE_T - 1);
    check("R4 full count needed", uart_en, 1);
    ticks(1);
    check("R4 idle after full count", uart_en, 0);
  endtask

  task automatic t_wake_char_only();
    bit v;
    rxd_pulse();
    send_byte(v);
    check("R12 wake char dropped", v, 0);
    ticks(WAKE_T);
    check("R12 active after delay", idle_flag, 0);
    ticks(IDLE_T);
    check("R12 back to idle", uart_en, 0);
  endtask

  task automatic t_hwfc_dtr();
    hwfc_en = 1'b1;
    rxd_pulse();
    check("R6 data edge ignored with flow control", uart_en, 0);
    @(negedge clk);
    dtr_in = 1'b1;
    cyc(5);
    check("R8 dtr edge wakes", uart_en, 1);
    dtr_in = 1'b0;
    hwfc_en = 1'b0;
    cyc(3);
    ticks(WAKE_T);
    check("R8 active after delay", idle_flag, 0);
  endtask

  task automatic t_mode4();
    bit v;
    mode_sel = 3'd4;
    send_byte(v);
    ticks(IDLE_T);
    check("R3 mode4 idle", uart_en, 0);
    rxd_pulse();
    check("R5 mode4 data edge wakes", uart_en, 1);
    ticks(WAKE_T);
  endtask

  task automatic t_mode_dtr();
    bit v;
    dtr_in = 1'b0;
    hwfc_en = 1'b1;
    mode_sel = 3'd3;
    cyc(3);
    check("R9 dtr off idle", uart_en, 0);
    check("R11 cts low idle", cts_out, 0);
    rxd_pulse();
    check("R9 data edge ignored", uart_en, 0);
    send_byte(v);
    check("R9 data dropped", v, 0);
    @(negedge clk);
    dtr_in = 1'b1;
    cyc(5);
    check("R9 dtr on wakes", uart_en, 1);
    check("R11 cts high when enabled", cts_out, 1);
    ticks(WAKE_T);
    ticks(IDLE_T * 3);
    check("R9 held active", idle_flag, 0);
    dtr_in = 1'b0;
    cyc(4);
    check("R9 dtr off sleeps", uart_en, 0);
    check("R11 cts follows", cts_out, 0);
  endtask

  task automatic t_mode_rts();
    mode_sel = 3'd2;
    rts_in = 1'b0;
    cyc(2);
    check("R11 cts high outside mode 3", cts_out, 1);
    rxd_pulse();
    check("R10 data edge ignored", uart_en, 0);
    @(negedge clk);
    rts_in = 1'b1;
    cyc(5);
    check("R10 rts wakes", uart_en, 1);
    ticks(WAKE_T);
    ticks(IDLE_T * 3);
    check("R10 held active", idle_flag, 0);
    rts_in = 1'b0;
    cyc(4);
    check("R10 rts off sleeps", uart_en, 0);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    done = 1'b0;
    t_reset();
    t_mode_off();
    t_timeout();
    t_wake_data();
    t_restart();
    t_wake_char_only();
    t_hwfc_dtr();
    t_mode4();
    t_mode_dtr();
    t_mode_rts();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule